// File: doc/BRIEF.md
# Serial Audio Transmitter

This block converts a pair of parallel 24-bit audio words (left and right) into the three-wire serial stream that a DAC or DSP expects: a bit clock, a word clock and a data line. The bit and word clocks come from dividing the system clock. The system clock may run at 128, 256, 384 or 512 times the sample rate, and a 2-bit select tells the block which of these applies. The bit clock always runs at 64 times the sample rate, so each channel slot is 32 bit clocks wide.

Software or upstream logic presents new words together with a one-cycle strobe. The words are held and then sent from the start of the next frame. A 2-bit format select picks one of four layouts: 16-bit right-justified, 24-bit right-justified, 24-bit left-justified or I2S. The polarity of the word clock follows the selected format. Data is sent MSB first in two's complement. Data and word clock change on the falling bit-clock edge, so the receiver samples on the rising edge.

Top module: `serial_audio_tx`

## Requirements
- R1: While reset is asserted (synchronous, active low), `bclk_o`, `lrck_o` and `sdata_o` are all low. After release, the first falling edge of `bclk_o` begins bit position 0 of the left slot.
- R2: `bclk_o` holds each level for `ratio_sel`+1 system clock cycles (00 = 128 fs, 01 = 256 fs, 10 = 384 fs, 11 = 512 fs). The first rise comes `ratio_sel`+1 cycles after reset release.
- R3: A frame is 64 bit-clock periods: 32 falling edges for the left slot, then 32 for the right slot. `lrck_o` therefore changes level only once every 32 falling edges of `bclk_o`.
- R4: `lrck_o` and `sdata_o` change only on the system clock edge where `bclk_o` goes from high to low.
- R5: With `fmt_sel` 00, 01 or 10, `lrck_o` is high during the left slot and low during the right slot. With `fmt_sel` 11 (I2S), it is low during the left slot and high during the right slot.
- R6: With `fmt_sel` 00, slot positions 16..31 carry sample bits 23 down to 8, and positions 0..15 are low.
- R7: With `fmt_sel` 01, slot positions 8..31 carry sample bits 23 down to 0, and positions 0..7 are low.
- R8: With `fmt_sel` 10, slot positions 0..23 carry sample bits 23 down to 0, and positions 24..31 are low.
- R9: With `fmt_sel` 11, position 0 is low, positions 1..24 carry sample bits 23 down to 0 (the MSB one bit clock after the `lrck_o` edge), and positions 25..31 are low.
- R10: A high `sample_stb` captures `left_word` and `right_word`. The captured pair is sent in the next frame that begins on a later cycle. A strobe in the same cycle a frame begins, or in the middle of a frame, does not change the frame in flight. Without a new strobe, the last captured pair is sent again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 128/256/384/512 times the sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| ratio_sel | input | 2 | System-clock-to-sample-rate ratio select |
| fmt_sel | input | 2 | Serial format select |
| sample_stb | input | 1 | One-cycle strobe that captures a new sample pair |
| left_word | input | 24 | Left-channel sample, two's complement |
| right_word | input | 24 | Right-channel sample, two's complement |
| bclk_o | output | 1 | Bit clock, 64 times the sample rate |
| lrck_o | output | 1 | Word clock, one period per frame |
| sdata_o | output | 1 | Serial data, MSB first, changes on the falling bit-clock edge |

## Verification
The bench targets the strobe that lands in exactly the cycle a frame begins. A design that forwards the newly written words there would send the new pair one frame early. It also uses full-scale negative and positive words, where a window placed one position off (most visibly the I2S one-bit delay) shows up as a misplaced sign bit or a stray trailing bit. Every ratio is combined with every format, because a divider that miscounts at the odd 384 fs ratio or at the 128 fs ratio with no idle count would stretch or shrink the bit clock. The bench also compares `lrck_o` polarity per format, which catches a design that keeps justified polarity in I2S mode.

// File: rtl/serial_audio_pkg.sv
// Shared types for the serial audio transmitter.
package serial_audio_pkg;

    // Serial layout selected by the 2-bit format input.
    typedef enum logic [1:0] {
        FMT_RJ16 = 2'b00,
        FMT_RJ24 = 2'b01,
        FMT_LJ24 = 2'b10,
        FMT_I2S  = 2'b11
    } audio_fmt_e;

endpackage

// File: rtl/sa_bclk_div.sv
// Bit-clock divider.
// Toggles bclk every (half_sel+1) system clock cycles and flags the cycle in
// which bclk goes from high to low. Assumes half_sel changes only in reset.
module sa_bclk_div #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] half_sel,
    output logic             bclk,
    output logic             fall_tick
);

    logic [SEL_W-1:0] cnt_q;
    logic             wrap;

    assign wrap      = (cnt_q >= half_sel);
    assign fall_tick = wrap & bclk;

    // Count the cycles of one half period and toggle the bit clock at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            bclk  <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            bclk  <= ~bclk;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sa_slot_seq.sv
// Frame slot sequencer.
// Steps a position counter through 2*CH_SLOTS bit positions, one per falling
// bit-clock edge. Presents the position that the next output bit belongs to
// and flags the step into position 0 (start of frame).
// Assumes CH_SLOTS is a power of two.
module sa_slot_seq #(
    parameter int CH_SLOTS = 32,
    localparam int SLOT_W  = $clog2(2 * CH_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [SLOT_W-1:0] slot_nxt,
    output logic              frame_start
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(2 * CH_SLOTS - 1);

    logic [SLOT_W-1:0] slot_q;

    assign slot_nxt    = (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
    assign frame_start = adv && (slot_nxt == '0);

    // Advance the position on each falling bit-clock edge; reset parks it at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= LAST_SLOT;
        end else if (adv) begin
            slot_q <= slot_nxt;
        end
    end

endmodule

// File: rtl/sa_bit_mapper.sv
// Slot bit mapper.
// For a position inside one channel slot, returns the sample bit that the
// selected format places there, or 0 outside the format's data window.
// Purely combinational.
module sa_bit_mapper
    import serial_audio_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int SHORT_W  = 16,
    parameter int CH_SLOTS = 32,
    localparam int POS_W   = $clog2(CH_SLOTS)
) (
    input  audio_fmt_e          fmt,
    input  logic [POS_W-1:0]    pos,
    input  logic [SAMPLE_W-1:0] word,
    output logic                bit_o
);

    int                  win_start;
    int                  win_len;
    int                  rel;
    logic [SAMPLE_W-1:0] shifted;

    // Place the data window for the chosen format.
    always_comb begin
        unique case (fmt)
            FMT_RJ16: begin win_start = CH_SLOTS - SHORT_W;  win_len = SHORT_W;  end
            FMT_RJ24: begin win_start = CH_SLOTS - SAMPLE_W; win_len = SAMPLE_W; end
            FMT_LJ24: begin win_start = 0;                   win_len = SAMPLE_W; end
            default:  begin win_start = 1;                   win_len = SAMPLE_W; end
        endcase
    end

    // Pick the bit at the position's offset into the window, MSB first.
    always_comb begin
        rel     = int'(pos) - win_start;
        shifted = '0;
        bit_o   = 1'b0;
        if (rel >= 0 && rel < win_len) begin
            shifted = word << rel;
            bit_o   = shifted[SAMPLE_W-1];
        end
    end

endmodule

// File: rtl/serial_audio_tx.sv
// Serial audio transmitter (top).
// Holds the last strobed sample pair, hands it to the frame at the next frame
// start, and shifts it out on sdata_o with a bit clock of 64 fs and a word
// clock whose polarity follows the format. Outputs change with the falling
// bit clock. Assumes ratio_sel changes only while reset is asserted.
module serial_audio_tx
    import serial_audio_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int SHORT_W  = 16,
    parameter int CH_SLOTS = 32,
    parameter int SEL_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SEL_W-1:0]    ratio_sel,
    input  logic [1:0]          fmt_sel,
    input  logic                sample_stb,
    input  logic [SAMPLE_W-1:0] left_word,
    input  logic [SAMPLE_W-1:0] right_word,
    output logic                bclk_o,
    output logic                lrck_o,
    output logic                sdata_o
);

    localparam int SLOT_W = $clog2(2 * CH_SLOTS);
    localparam int POS_W  = SLOT_W - 1;

    logic                fall_tick;
    logic                frame_start;
    logic [SLOT_W-1:0]   slot_nxt;
    logic                right_half;
    logic [POS_W-1:0]    pos;
    logic [SAMPLE_W-1:0] hold_l_q, hold_r_q;
    logic [SAMPLE_W-1:0] act_l_q, act_r_q;
    logic [SAMPLE_W-1:0] cur_word;
    logic                map_bit;
    audio_fmt_e          fmt;

    assign fmt        = audio_fmt_e'(fmt_sel);
    assign right_half = slot_nxt[SLOT_W-1];
    assign pos        = slot_nxt[POS_W-1:0];

    sa_bclk_div #(
        .SEL_W(SEL_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_sel (ratio_sel),
        .bclk     (bclk_o),
        .fall_tick(fall_tick)
    );

    sa_slot_seq #(
        .CH_SLOTS(CH_SLOTS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (fall_tick),
        .slot_nxt   (slot_nxt),
        .frame_start(frame_start)
    );

    // Capture the strobed sample pair into the holding registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_l_q <= '0;
            hold_r_q <= '0;
        end else if (sample_stb) begin
            hold_l_q <= left_word;
            hold_r_q <= right_word;
        end
    end

    // Hand the held pair to the frame that is starting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_l_q <= '0;
            act_r_q <= '0;
        end else if (frame_start) begin
            act_l_q <= hold_l_q;
            act_r_q <= hold_r_q;
        end
    end

    // Select the word for the coming bit; position 0 reads the pair being handed over.
    always_comb begin
        if (right_half) begin
            cur_word = act_r_q;
        end else if (frame_start) begin
            cur_word = hold_l_q;
        end else begin
            cur_word = act_l_q;
        end
    end

    sa_bit_mapper #(
        .SAMPLE_W(SAMPLE_W),
        .SHORT_W (SHORT_W),
        .CH_SLOTS(CH_SLOTS)
    ) u_map (
        .fmt  (fmt),
        .pos  (pos),
        .word (cur_word),
        .bit_o(map_bit)
    );

    // Update word clock and data together on the falling bit-clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lrck_o  <= 1'b0;
            sdata_o <= 1'b0;
        end else if (fall_tick) begin
            lrck_o  <= (fmt == FMT_I2S) ? right_half : ~right_half;
            sdata_o <= map_bit;
        end
    end

endmodule

// File: rtl/sa_tx_checker.sv
// Protocol checker for serial_audio_tx, attached by bind.
// Watches the three serial outputs and the ratio select, and tracks bit-clock
// half periods and falling edges per word-clock level in small counters.
module sa_tx_checker #(
    parameter int SEL_W    = 2,
    parameter int CH_SLOTS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] ratio_sel,
    input logic             bclk,
    input logic             lrck,
    input logic             sdata
);

    logic       bclk_d, lrck_d;
    logic       b_seen, l_seen;
    logic [7:0] run_q;
    logic [7:0] fall_cnt_q;
    logic       fell_now, lrck_chg;

    assign fell_now = bclk_d && !bclk;
    assign lrck_chg = (lrck != lrck_d);

    // Track the bit-clock half-period length and falls between word-clock changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_d     <= 1'b0;
            lrck_d     <= 1'b0;
            b_seen     <= 1'b0;
            l_seen     <= 1'b0;
            run_q      <= '0;
            fall_cnt_q <= '0;
        end else begin
            bclk_d <= bclk;
            lrck_d <= lrck;
            if (bclk != bclk_d) begin
                b_seen <= 1'b1;
                run_q  <= '0;
            end else if (run_q != 8'hFF) begin
                run_q <= run_q + 1'b1;
            end
            if (lrck_chg) begin
                l_seen     <= 1'b1;
                fall_cnt_q <= '0;
            end else if (fell_now && fall_cnt_q != 8'hFF) begin
                fall_cnt_q <= fall_cnt_q + 1'b1;
            end
        end
    end

    // R1: reset drives every output low
    assert_reset_low_R1: assert property (@(posedge clk)
        !rst_n |=> (!bclk && !lrck && !sdata));

    // R2: each bit-clock level lasts ratio_sel+1 system cycles
    assert_half_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk != bclk_d && b_seen) |-> (run_q == 8'(ratio_sel)));

    // R3: word clock changes once per CH_SLOTS falling edges
    assert_lrck_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lrck_chg && l_seen) |-> (fall_cnt_q == 8'(CH_SLOTS - 1)));

    // R4: word clock and data move only with the falling bit clock
    assert_change_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(bclk) |-> ($stable(lrck) && $stable(sdata)));

endmodule

bind serial_audio_tx sa_tx_checker #(
    .SEL_W   (SEL_W),
    .CH_SLOTS(CH_SLOTS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ratio_sel(ratio_sel),
    .bclk     (bclk_o),
    .lrck     (lrck_o),
    .sdata    (sdata_o)
);

// File: tb/tb_serial_audio_tx.sv
// Bench for serial_audio_tx: a behavioural model driven by the cycle count
// since reset predicts all three outputs, compared at every falling clk edge.
module tb_serial_audio_tx;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  ratio_sel;
    logic [1:0]  fmt_sel;
    logic        sample_stb;
    logic [23:0] left_word, right_word;
    logic        bclk_o, lrck_o, sdata_o;

    always #5 clk = ~clk;

    serial_audio_tx dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ratio_sel (ratio_sel),
        .fmt_sel   (fmt_sel),
        .sample_stb(sample_stb),
        .left_word (left_word),
        .right_word(right_word),
        .bclk_o    (bclk_o),
        .lrck_o    (lrck_o),
        .sdata_o   (sdata_o)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    bit armed  = 0;

    // Model state
    int          k;
    logic [23:0] m_hold_l, m_hold_r, m_fr_l, m_fr_r;
    logic        e_bclk, e_lrck, e_sd;

    // Expected bit at position pos of a slot for each format (R6..R9)
    function automatic logic ref_bit(int fmt, int pos, logic [23:0] w);
        case (fmt)
            0: return (pos >= 16) ? w[39 - pos] : 1'b0;
            1: return (pos >= 8) ? w[31 - pos] : 1'b0;
            2: return (pos < 24) ? w[23 - pos] : 1'b0;
            default: return (pos >= 1 && pos <= 24) ? w[24 - pos] : 1'b0;
        endcase
    endfunction

    // Behavioural reference, advanced on every rising clk edge
    always @(posedge clk) begin
        if (!rst_n) begin
            k = 0;
            m_hold_l = '0; m_hold_r = '0; m_fr_l = '0; m_fr_r = '0;
            e_bclk = 0; e_lrck = 0; e_sd = 0;
        end else begin
            int h;
            h = int'(ratio_sel) + 1;
            k = k + 1;
            if (k % (2 * h) == 0) begin
                int slot;
                int ch;
                int pos;
                slot = ((k / (2 * h)) - 1) % 64;
                if (slot == 0) begin
                    m_fr_l = m_hold_l;
                    m_fr_r = m_hold_r;
                end
                ch  = slot / 32;
                pos = slot % 32;
                e_lrck = (fmt_sel == 2'b11) ? (ch == 1) : (ch == 0);
                e_sd   = ref_bit(int'(fmt_sel), pos, (ch == 1) ? m_fr_r : m_fr_l);
            end
            e_bclk = ((k / h) % 2) == 1;
            if (sample_stb) begin
                m_hold_l = left_word;
                m_hold_r = right_word;
            end
        end
    end

    // Comparison against the model away from the active edge
    logic p_bclk, p_lrck, p_sd, p_rst;
    string sd_tag [4] = '{"R6", "R7", "R8", "R9"};

    always @(negedge clk) begin
        if (armed && !done) begin
            string tl, td;
            tl = rst_n ? "R3/R5" : "R1";
            td = rst_n ? {sd_tag[fmt_sel], "/R10"} : "R1";
            checks += 3;
            if (bclk_o !== e_bclk) begin
                errors++;
                $display("FAIL %s bclk_o k=%0d actual=%b expected=%b", rst_n ? "R2" : "R1", k, bclk_o, e_bclk);
            end
            if (lrck_o !== e_lrck) begin
                errors++;
                $display("FAIL %s lrck_o k=%0d fmt=%0d actual=%b expected=%b", tl, k, fmt_sel, lrck_o, e_lrck);
            end
            if (sdata_o !== e_sd) begin
                errors++;
                $display("FAIL %s sdata_o k=%0d fmt=%0d actual=%b expected=%b", td, k, fmt_sel, sdata_o, e_sd);
            end
            // R4: lrck/sdata move only together with a falling bit clock
            if (rst_n && p_rst) begin
                checks++;
                if ((lrck_o !== p_lrck || sdata_o !== p_sd) && !(p_bclk && !bclk_o)) begin
                    errors++;
                    $display("FAIL R4 change without bclk fall k=%0d actual bclk %b->%b expected 1->0", k, p_bclk, bclk_o);
                end
            end
        end
        p_bclk = bclk_o; p_lrck = lrck_o; p_sd = sdata_o; p_rst = rst_n;
    end

    // Pulse sample_stb so that it is seen at the rising edge where k becomes target
    task automatic strobe_at(int target, logic [23:0] l, logic [23:0] r);
        while (k != target - 1) @(negedge clk);
        sample_stb = 1'b1;
        left_word  = l;
        right_word = r;
        @(negedge clk);
        sample_stb = 1'b0;
    endtask

    task automatic run_until(int target);
        while (k < target) @(negedge clk);
    endtask

    initial begin
        rst_n = 0; sample_stb = 0; ratio_sel = 0; fmt_sel = 0;
        left_word = '0; right_word = '0;
        p_bclk = 0; p_lrck = 0; p_sd = 0; p_rst = 0;
        @(posedge clk);
        armed = 1;
        for (int f = 0; f < 4; f++) begin
            for (int r = 0; r < 4; r++) begin
                int h;
                int fs1;
                h = r + 1;
                // R1: reset, with new format and ratio applied while held
                @(negedge clk);
                rst_n = 0;
                fmt_sel   = 2'(f);
                ratio_sel = 2'(r);
                repeat (3) @(negedge clk);
                rst_n = 1;
                fs1 = 2 * h + 128 * h;
                // R10: pair before first frame, full-scale extremes on alternate runs
                if (((f + r) % 2) == 0)
                    strobe_at(5, 24'h800000, 24'h7FFFFF);
                else
                    strobe_at(5, 24'h7FFFFF, 24'h800001);
                // R10: strobe in the very cycle frame 1 begins must not reach frame 1
                strobe_at(fs1, 24'($urandom), 24'($urandom));
                // R10: mid-frame strobe replaces the held pair for frame 2 only
                strobe_at(fs1 + 37 * h, 24'($urandom), 24'($urandom));
                // Frame 3 repeats the pair without a new strobe
                run_until(fs1 + 256 * h + 10);
            end
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule